// File: doc/BRIEF.md
# Channel Interrupt Status Unit

This block keeps the interrupt state of one bus channel of a two-wire serial controller. It holds a 15-bit enable register and a 16-bit status register. The command engine sets status bits with one-cycle event pulses, and software clears them with write-one-to-clear accesses. A single pending line is passed up to a global interrupt summary. The line is set only when an interrupt is raised, which happens when the engine signals that a command finished. At that moment the status register is first reduced to the enabled bits.

The block can also restart a read on its own. If software acknowledges a completed receive while the engine still has a receive command queued, the unit issues a one-cycle re-arm request so that the engine fetches the next byte. The same update then repeats the raise evaluation.

The pending line comes from a two-state machine. SUM_IDLE moves to SUM_PENDING on the transition "raise with nonzero result". SUM_PENDING returns to SUM_IDLE on the transition "status write leaves zero". In every other case the state is held.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the enable register, the status register, the pending output and the re-arm output are all zero.
- R2: An enable write stores bits 14:0 of the written data. Bit 15 of the enable register always reads zero.
- R3: An event pulse on bit k of the event input sets status bit k on the next clock edge, and the bit holds until it is cleared. Bit assignments: 0 TX ACK, 1 TX NAK, 2 RX done, 3 arbitration loss, 4 normal stop, 5 abnormal stop, 6 clock-line timeout, 13 bus recovery done, 14 data-line timeout, 15 target inactive timeout.
- R4: A status write clears every status bit in 14:0 whose bit in the written data is 1. Bit 15, and every bit written as 0, is left unchanged.
- R5: An event pulse in the same cycle as a status write that clears the same bit leaves that bit set.
- R6: When the command-done input is high, the updated status (after clears and events) is ANDed with the enable register. The pending output goes high if the result is nonzero.
- R7: A status write after which the status register is zero drives pending low on the next edge. Any other write leaves pending unchanged.
- R8: A status write with data bit 2 = 1, while status bit 2 is set and receive-queued is high, produces a one-cycle re-arm pulse on the next edge. That same update performs the raise evaluation of R6.
- R9: No re-arm pulse occurs if status bit 2 was clear, if data bit 2 is 0, or if receive-queued is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 16 | Event pulses from the command engine, one bit per status position |
| cmd_done_i | input | 1 | Engine finished a command; raise evaluation |
| rx_queued_i | input | 1 | A receive or last-receive command is still queued |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 16 | Enable register write data |
| sts_wr_i | input | 1 | Status register write strobe (write-one-to-clear) |
| sts_wdata_i | input | 16 | Status register write data |
| en_o | output | 16 | Enable register contents |
| sts_o | output | 16 | Status register contents |
| pending_o | output | 1 | Channel pending bit for the global summary |
| rearm_o | output | 1 | One-cycle receive re-arm request |

## Verification
Every result is registered, so each one appears exactly one clock edge after the inputs that caused it. This covers stored enables, set or cleared status bits, the pending transition and the re-arm pulse. The bench drives a single stimulus on a falling edge and holds it across one rising edge. It compares all four outputs one time unit after that edge against an arithmetic model updated with the same cycle rule. It then removes the stimulus, so the one-cycle pulses are also seen to drop on the following edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned IRQ_STS_W  = 16;
    localparam int unsigned IRQ_RX_BIT = 2;

    typedef enum logic {
        SUM_IDLE    = 1'b0,
        SUM_PENDING = 1'b1
    } sum_state_e;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int unsigned W = irq_pkg::IRQ_STS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_o
);
    localparam logic [W-1:0] WMASK = {1'b0, {(W-1){1'b1}}};

    always_ff @(posedge clk) begin
        if (!rst_n)    en_o <= '0;
        else if (wr_i) en_o <= wdata_i & WMASK;
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int unsigned W      = irq_pkg::IRQ_STS_W,
    parameter int unsigned RX_BIT = irq_pkg::IRQ_RX_BIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         cmd_done_i,
    input  logic         rx_queued_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] sts_o,
    output logic [W-1:0] sts_next_o,
    output logic         raise_o,
    output logic         rearm_o
);
    localparam logic [W-1:0] CMASK = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] clr;
    logic         fire;
    logic [W-1:0] merged;

    always_comb begin
        clr        = wr_i ? (wdata_i & CMASK) : '0;
        fire       = wr_i && sts_o[RX_BIT] && wdata_i[RX_BIT] && rx_queued_i;
        merged     = (sts_o & ~clr) | evt_i;
        raise_o    = cmd_done_i || fire;
        sts_next_o = raise_o ? (merged & en_i) : merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_o   <= '0;
            rearm_o <= 1'b0;
        end else begin
            sts_o   <= sts_next_o;
            rearm_o <= fire;
        end
    end
endmodule

// File: rtl/irq_summary_fsm.sv
module irq_summary_fsm #(
    parameter int unsigned W = irq_pkg::IRQ_STS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         raise_i,
    input  logic         wr_i,
    input  logic [W-1:0] sts_next_i,
    output logic         pending_o
);
    import irq_pkg::*;

    sum_state_e state_q, state_d;
    logic       set_req, clr_req;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SUM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        set_req = raise_i && (sts_next_i != '0);
        clr_req = wr_i && (sts_next_i == '0);
        state_d = state_q;
        unique case (state_q)
            SUM_IDLE:    if (set_req) state_d = SUM_PENDING;
            SUM_PENDING: if (clr_req && !set_req) state_d = SUM_IDLE;
            default:     state_d = SUM_IDLE;
        endcase
    end

    always_comb begin
        pending_o = (state_q == SUM_PENDING);
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
    parameter int unsigned STS_W  = irq_pkg::IRQ_STS_W,
    parameter int unsigned RX_BIT = irq_pkg::IRQ_RX_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] evt_i,
    input  logic             cmd_done_i,
    input  logic             rx_queued_i,
    input  logic             en_wr_i,
    input  logic [STS_W-1:0] en_wdata_i,
    input  logic             sts_wr_i,
    input  logic [STS_W-1:0] sts_wdata_i,
    output logic [STS_W-1:0] en_o,
    output logic [STS_W-1:0] sts_o,
    output logic             pending_o,
    output logic             rearm_o
);
    logic [STS_W-1:0] sts_next;
    logic             raise;

    irq_enable_reg #(.W(STS_W)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr_i),
        .wdata_i (en_wdata_i),
        .en_o    (en_o)
    );

    irq_status_reg #(.W(STS_W), .RX_BIT(RX_BIT)) u_sts (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .cmd_done_i  (cmd_done_i),
        .rx_queued_i (rx_queued_i),
        .wr_i        (sts_wr_i),
        .wdata_i     (sts_wdata_i),
        .en_i        (en_o),
        .sts_o       (sts_o),
        .sts_next_o  (sts_next),
        .raise_o     (raise),
        .rearm_o     (rearm_o)
    );

    irq_summary_fsm #(.W(STS_W)) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_i    (raise),
        .wr_i       (sts_wr_i),
        .sts_next_i (sts_next),
        .pending_o  (pending_o)
    );
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
    parameter int unsigned STS_W  = irq_pkg::IRQ_STS_W,
    parameter int unsigned RX_BIT = irq_pkg::IRQ_RX_BIT
) (
    input logic             clk,
    input logic             rst_n,
    input logic [STS_W-1:0] evt_i,
    input logic             cmd_done_i,
    input logic             rx_queued_i,
    input logic             en_wr_i,
    input logic [STS_W-1:0] en_wdata_i,
    input logic             sts_wr_i,
    input logic [STS_W-1:0] sts_wdata_i,
    input logic [STS_W-1:0] en_o,
    input logic [STS_W-1:0] sts_o,
    input logic             pending_o,
    input logic             rearm_o
);
    localparam logic [STS_W-1:0] LOWMASK = {1'b0, {(STS_W-1){1'b1}}};

    logic rx_ack;
    assign rx_ack = sts_wr_i && sts_o[RX_BIT] && sts_wdata_i[RX_BIT] && rx_queued_i;

    // R2
    en_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> (en_o == ($past(en_wdata_i) & LOWMASK)));

    // R3
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i != '0) && !cmd_done_i && !rx_ack) |=> ((sts_o & $past(evt_i)) == $past(evt_i)));

    // R4
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_i && (evt_i == '0) && !cmd_done_i && !rx_ack)
        |=> ((sts_o & $past(sts_wdata_i) & LOWMASK) == '0));

    // R6
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_o) |-> $past(cmd_done_i || rx_ack));

    // R7
    pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending_o) |-> (sts_o == '0));

    // R8
    rearm_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |=> rearm_o);

    // R9
    rearm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ack |=> !rearm_o);
endmodule

bind irq_status_unit irq_status_unit_chk #(.STS_W(STS_W), .RX_BIT(RX_BIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .cmd_done_i  (cmd_done_i),
    .rx_queued_i (rx_queued_i),
    .en_wr_i     (en_wr_i),
    .en_wdata_i  (en_wdata_i),
    .sts_wr_i    (sts_wr_i),
    .sts_wdata_i (sts_wdata_i),
    .en_o        (en_o),
    .sts_o       (sts_o),
    .pending_o   (pending_o),
    .rearm_o     (rearm_o)
);

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt = '0;
    logic        done = 1'b0;
    logic        rxq = 1'b0;
    logic        en_wr = 1'b0;
    logic [15:0] en_wd = '0;
    logic        sts_wr = 1'b0;
    logic [15:0] sts_wd = '0;
    logic [15:0] en_o, sts_o;
    logic        pending_o, rearm_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    logic [15:0] m_en = '0, m_sts = '0;
    logic        m_pend = 1'b0, m_rearm = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .cmd_done_i(done),
        .rx_queued_i(rxq), .en_wr_i(en_wr), .en_wdata_i(en_wd),
        .sts_wr_i(sts_wr), .sts_wdata_i(sts_wd), .en_o(en_o),
        .sts_o(sts_o), .pending_o(pending_o), .rearm_o(rearm_o)
    );

    task automatic cmp(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        cmp(req, "en", en_o, m_en);
        cmp(req, "sts", sts_o, m_sts);
        cmp(req, "pending", {15'd0, pending_o}, {15'd0, m_pend});
        cmp(req, "rearm", {15'd0, rearm_o}, {15'd0, m_rearm});
    endtask

    // one cycle: drive at falling edge, model update, compare just after rising edge
    task automatic step(input string req, input logic [15:0] e, input logic d,
                        input logic q, input logic ew, input logic [15:0] ed,
                        input logic sw, input logic [15:0] sd);
        logic [15:0] clr, nxt;
        logic        fire, raise;
        evt = e; done = d; rxq = q; en_wr = ew; en_wd = ed; sts_wr = sw; sts_wd = sd;
        clr   = sw ? (sd & 16'h7FFF) : 16'h0;
        fire  = sw && m_sts[2] && sd[2] && q;
        nxt   = (m_sts & ~clr) | e;
        raise = d || fire;
        if (raise) nxt = nxt & m_en;
        if (raise && nxt != 16'h0) m_pend = 1'b1;
        else if (sw && nxt == 16'h0) m_pend = 1'b0;
        m_sts = nxt;
        m_rearm = fire;
        if (ew) m_en = ed & 16'h7FFF;
        @(posedge clk); #1;
        check_all(req);
        @(negedge clk);
        evt = '0; done = 0; rxq = 0; en_wr = 0; en_wd = '0; sts_wr = 0; sts_wd = '0;
    endtask

    task automatic idle(input string req);
        step(req, 16'h0, 0, 0, 0, 16'h0, 0, 16'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] pats [5];
        pats[0] = 16'h0000; pats[1] = 16'h0001; pats[2] = 16'h0050;
        pats[3] = 16'h7FFF; pats[4] = 16'h2A2A;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check_all("R1");

        // R2 enable storage, bit 15 dropped
        step("R2", 16'h0, 0, 0, 1, 16'hFFFF, 0, 16'h0);
        step("R2", 16'h0, 0, 0, 1, 16'h9234, 0, 16'h0);
        step("R2", 16'h0, 0, 0, 1, 16'hFFFF, 0, 16'h0);

        // R3 / R4 each event bit set, then cleared by write-one
        for (int b = 0; b < 16; b++) begin
            step("R3", 16'h1 << b, 0, 0, 0, 16'h0, 0, 16'h0);
            idle("R3");
            step("R4", 16'h0, 0, 0, 0, 16'h0, 1, 16'hFFFF);
        end
        // bit 15 survived the write; removed only by a raise (enable bit 15 is zero)
        step("R6", 16'h0, 1, 0, 0, 16'h0, 0, 16'h0);

        // R4 writing zeros leaves bits alone
        step("R3", 16'h0033, 0, 0, 0, 16'h0, 0, 16'h0);
        step("R4", 16'h0, 0, 0, 0, 16'h0, 1, 16'h0002);
        step("R4", 16'h0, 0, 0, 0, 16'h0, 1, 16'h0000);

        // R5 event beats a clear of the same bit
        step("R5", 16'h0001, 0, 0, 0, 16'h0, 1, 16'h0031);
        step("R4", 16'h0, 0, 0, 0, 16'h0, 1, 16'h7FFF);

        // R6 / R7 raise under several enable masks
        foreach (pats[i]) begin
            step("R2", 16'h0, 0, 0, 1, pats[i], 0, 16'h0);
            step("R6", 16'h207F, 1, 0, 0, 16'h0, 0, 16'h0);
            step("R7", 16'h0, 0, 0, 0, 16'h0, 1, 16'h0001);
            step("R7", 16'h0, 0, 0, 0, 16'h0, 1, 16'h7FFF);
            idle("R7");
        end
        // raise with zero result does not set pending
        step("R2", 16'h0, 0, 0, 1, 16'h0000, 0, 16'h0);
        step("R6", 16'h0, 1, 0, 0, 16'h0, 0, 16'h0);

        // R8 / R9 all combinations of RX-done set, bit written, queued
        step("R2", 16'h0, 0, 0, 1, 16'h7FFF, 0, 16'h0);
        for (int c = 0; c < 8; c++) begin
            if (c[0]) step("R3", 16'h0004, 0, 0, 0, 16'h0, 0, 16'h0);
            step(c == 7 ? "R8" : "R9", 16'h0, 0, c[2], 0, 16'h0, 1, c[1] ? 16'h0004 : 16'h0001);
            idle("R8");
            step("R4", 16'h0, 0, 0, 0, 16'h0, 1, 16'h7FFF);
        end
        // R8 re-arm update masks the status and raises pending
        step("R2", 16'h0, 0, 0, 1, 16'h0014, 0, 16'h0);
        step("R3", 16'h0034, 0, 0, 0, 16'h0, 0, 16'h0);
        step("R8", 16'h0, 0, 1, 0, 16'h0, 1, 16'h0004);
        idle("R8");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule